// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal sync, vertical sync and data-enable strobes for a progressive raster display, one pixel per clock. Software programs the length of each line and frame region through a small write port. Each horizontal and vertical region is held as its length minus one: active, front porch, sync pulse and back porch. A control word switches each strobe on and off and sets its polarity. The block also passes two polarity flags, one for pixel data and one for the output clock edge, to the physical-interface logic downstream.

A pair of position counters (`x_o`, `y_o`) tells a downstream pixel source which pixel is being scanned. When the vertical sync pulse begins, a sticky status flag is set. That flag drives a level interrupt unless a mask bit blocks it, and software clears it by writing a one. Writing any value to the restart register sends the raster back to the first pixel of a frame. Writes to the timing registers are staged and take effect only from the next frame onwards, so a frame never mixes old and new geometry.

Top module: `raster_timing_gen`

## Requirements
- R1: Register addresses are: 0 horizontal front porch, 1 hsync width, 2 horizontal back porch, 3 horizontal active. Each holds its length minus one. A line scans active pixels, then front porch, then sync, then back porch. `x_o` counts from 0 at the first active pixel up to the line total minus one, then wraps to 0.
- R2: Addresses 4 to 7 hold the vertical front porch, vsync width, vertical back porch and vertical active, in that order, each as its length in lines minus one. A frame runs through its lines in the same order as R1. `y_o` advances when `x_o` wraps, and it wraps to 0 after the last back-porch line.
- R3: The raw data-enable is high only when `x_o` and `y_o` are both inside their active regions.
- R4: The control word at address 8 has enable bits for hsync (bit 0), vsync (bit 2) and data-enable (bit 4). While an enable bit is zero, that output is held at its inactive level, which equals its invert bit.
- R5: Control bits 1, 3 and 5 invert hsync, vsync and data-enable. Bit 6 drives `pix_inv_o` and bit 7 drives `clk_inv_o`.
- R6: A write to address 9, whatever its data, makes the next cycle show `x_o`=0 and `y_o`=0, with the staged timing values loaded.
- R7: Timing writes go into staging registers. The counters use the new values only after the next frame wrap or restart.
- R8: The status flag (address 10, bit 0) is set after the cycle in which `x_o`=0 on the first vsync line. Writing 1 to that bit clears the flag. Writing 0 leaves it unchanged. When a set and a clear fall in the same cycle, the flag stays set.
- R9: The mask bit is at address 11, bit 0. `irq_o` equals the status flag AND NOT the mask, so a one masks the interrupt. The status flag stays set while the interrupt is masked.
- R10: After reset every control bit is zero, the mask is one, the status flag is clear and both counters are zero. All strobes and `irq_o` are therefore low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register address |
| wr_data_i | input | CNT_W | Register write data |
| hsync_o | output | 1 | Horizontal sync after enable and polarity |
| vsync_o | output | 1 | Vertical sync after enable and polarity |
| de_o | output | 1 | Data-enable after enable and polarity |
| pix_inv_o | output | 1 | Pixel data polarity flag |
| clk_inv_o | output | 1 | Output clock edge flag |
| x_o | output | CNT_W+2 | Horizontal position |
| y_o | output | CNT_W+2 | Vertical position |
| irq_o | output | 1 | Vertical sync interrupt |

## Verification
A small geometry is used: a 10-pixel line and a 7-line frame. It is sampled at every region edge, which catches an off-by-one error in any single length field and any mix-up in region order. A set of control words tries each combination of enable and invert, and separates a missing polarity flip from a disabled output that is not parked. Two scenarios test timing: a change to the active width made in the middle of a frame must keep the old width until the wrap, and a restart issued mid-line must return the raster home. The interrupt is checked before and after its set cycle, with the mask on and off, and with a clear that lands in the same cycle as a set.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned NTIM   = 8;

  typedef enum logic [ADDR_W-1:0] {
    A_HFP = 4'd0, A_HSW = 4'd1, A_HBP = 4'd2, A_HACT = 4'd3,
    A_VFP = 4'd4, A_VSW = 4'd5, A_VBP = 4'd6, A_VACT = 4'd7,
    A_CTRL = 4'd8, A_RESTART = 4'd9, A_ISTAT = 4'd10, A_IMASK = 4'd11
  } reg_addr_e;

  typedef struct packed {
    logic clk_inv;
    logic pix_inv;
    logic de_inv;
    logic de_en;
    logic v_inv;
    logic v_en;
    logic h_inv;
    logic h_en;
  } ctrl_t;
endpackage

// File: rtl/rtg_regs.sv
module rtg_regs import rtg_pkg::*; #(
  parameter int unsigned CNT_W  = 12,
  parameter int unsigned H_FP   = 15,
  parameter int unsigned H_SW   = 95,
  parameter int unsigned H_BP   = 47,
  parameter int unsigned H_ACT  = 639,
  parameter int unsigned V_FP   = 9,
  parameter int unsigned V_SW   = 1,
  parameter int unsigned V_BP   = 32,
  parameter int unsigned V_ACT  = 479
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          wr_addr_i,
  input  logic [CNT_W-1:0]           wr_data_i,
  input  logic                       frame_end_i,
  output logic [NTIM-1:0][CNT_W-1:0] tim_o,
  output ctrl_t                      ctrl_o,
  output logic                       mask_o,
  output logic                       restart_o,
  output logic                       clr_o
);
  localparam logic [NTIM-1:0][CNT_W-1:0] DEF = {
    CNT_W'(V_ACT), CNT_W'(V_BP), CNT_W'(V_SW), CNT_W'(V_FP),
    CNT_W'(H_ACT), CNT_W'(H_BP), CNT_W'(H_SW), CNT_W'(H_FP)
  };

  logic [NTIM-1:0][CNT_W-1:0] live_q, shad_q;

  assign restart_o = wr_en_i && (wr_addr_i == A_RESTART);
  assign clr_o     = wr_en_i && (wr_addr_i == A_ISTAT) && wr_data_i[0];

  for (genvar i = 0; i < NTIM; i++) begin : g_live
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                         live_q[i] <= DEF[i];
      else if (wr_en_i && (wr_addr_i == ADDR_W'(i)))       live_q[i] <= wr_data_i;
    end
  end

  // staged copy used by the counters; updated only at frame boundaries
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         shad_q <= DEF;
    else if (frame_end_i || restart_o)   shad_q <= live_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= '0;
      mask_o <= 1'b1;
    end else if (wr_en_i) begin
      if (wr_addr_i == A_CTRL)  ctrl_o <= ctrl_t'(wr_data_i[7:0]);
      if (wr_addr_i == A_IMASK) mask_o <= wr_data_i[0];
    end
  end

  assign tim_o = shad_q;
endmodule

// File: rtl/rtg_axis.sv
module rtg_axis #(
  parameter int unsigned CNT_W = 12,
  localparam int unsigned PW   = CNT_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] act_i,
  input  logic [CNT_W-1:0] fp_i,
  input  logic [CNT_W-1:0] sw_i,
  input  logic [CNT_W-1:0] bp_i,
  output logic [PW-1:0]    cnt_o,
  output logic             last_o,
  output logic             active_o,
  output logic             sync_o,
  output logic             sync_start_o
);
  logic [PW-1:0] e_act, e_fp, e_sw, e_tot;
  logic [PW-1:0] cnt_q;

  // region end positions (exclusive), each field stored as length-1
  assign e_act = {2'b00, act_i} + PW'(1);
  assign e_fp  = e_act + {2'b00, fp_i} + PW'(1);
  assign e_sw  = e_fp  + {2'b00, sw_i} + PW'(1);
  assign e_tot = e_sw  + {2'b00, bp_i} + PW'(1);

  assign last_o       = (cnt_q == e_tot - PW'(1));
  assign active_o     = (cnt_q < e_act);
  assign sync_o       = (cnt_q >= e_fp) && (cnt_q < e_sw);
  assign sync_start_o = (cnt_q == e_fp);
  assign cnt_o        = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (restart_i)  cnt_q <= '0;
    else if (step_i)     cnt_q <= last_o ? '0 : cnt_q + PW'(1);
  end
endmodule

// File: rtl/rtg_drive.sv
module rtg_drive import rtg_pkg::*; (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  ctrl_t ctrl_i,
  input  logic  h_raw_i,
  input  logic  v_raw_i,
  input  logic  de_raw_i,
  input  logic  set_i,
  input  logic  clr_i,
  input  logic  mask_i,
  output logic  hsync_o,
  output logic  vsync_o,
  output logic  de_o,
  output logic  pix_inv_o,
  output logic  clk_inv_o,
  output logic  stat_o,
  output logic  irq_o
);
  localparam int unsigned NSIG = 3;

  logic [NSIG-1:0] raw, en, inv, drv;

  assign raw = {de_raw_i, v_raw_i, h_raw_i};
  assign en  = {ctrl_i.de_en,  ctrl_i.v_en,  ctrl_i.h_en};
  assign inv = {ctrl_i.de_inv, ctrl_i.v_inv, ctrl_i.h_inv};

  // disabled strobe parks at its inactive level under the chosen polarity
  for (genvar i = 0; i < NSIG; i++) begin : g_pol
    assign drv[i] = en[i] ? (raw[i] ^ inv[i]) : inv[i];
  end

  assign hsync_o   = drv[0];
  assign vsync_o   = drv[1];
  assign de_o      = drv[2];
  assign pix_inv_o = ctrl_i.pix_inv;
  assign clk_inv_o = ctrl_i.clk_inv;

  logic stat_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     stat_q <= 1'b0;
    else if (set_i)  stat_q <= 1'b1;
    else if (clr_i)  stat_q <= 1'b0;
  end

  assign stat_o = stat_q;
  assign irq_o  = stat_q & ~mask_i;
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen import rtg_pkg::*; #(
  parameter int unsigned CNT_W  = 12,
  parameter int unsigned H_FP   = 15,
  parameter int unsigned H_SW   = 95,
  parameter int unsigned H_BP   = 47,
  parameter int unsigned H_ACT  = 639,
  parameter int unsigned V_FP   = 9,
  parameter int unsigned V_SW   = 1,
  parameter int unsigned V_BP   = 32,
  parameter int unsigned V_ACT  = 479,
  localparam int unsigned PW    = CNT_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o,
  output logic              pix_inv_o,
  output logic              clk_inv_o,
  output logic [PW-1:0]     x_o,
  output logic [PW-1:0]     y_o,
  output logic              irq_o
);
  logic [NTIM-1:0][CNT_W-1:0] tim;
  ctrl_t ctrl;
  logic  irq_mask, restart, st_clr, irq_stat, vs_set, frame_end;
  logic  h_last, h_act, h_sync, h_start;
  logic  v_last, v_act, v_sync, v_start;

  assign frame_end = h_last && v_last;
  assign vs_set    = v_start && (x_o == '0);

  rtg_regs #(
    .CNT_W(CNT_W), .H_FP(H_FP), .H_SW(H_SW), .H_BP(H_BP), .H_ACT(H_ACT),
    .V_FP(V_FP), .V_SW(V_SW), .V_BP(V_BP), .V_ACT(V_ACT)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .frame_end_i(frame_end), .tim_o(tim), .ctrl_o(ctrl),
    .mask_o(irq_mask), .restart_o(restart), .clr_o(st_clr)
  );

  rtg_axis #(.CNT_W(CNT_W)) u_hcnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(restart), .step_i(1'b1),
    .act_i(tim[A_HACT]), .fp_i(tim[A_HFP]), .sw_i(tim[A_HSW]), .bp_i(tim[A_HBP]),
    .cnt_o(x_o), .last_o(h_last), .active_o(h_act), .sync_o(h_sync),
    .sync_start_o(h_start)
  );

  rtg_axis #(.CNT_W(CNT_W)) u_vcnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(restart), .step_i(h_last),
    .act_i(tim[A_VACT]), .fp_i(tim[A_VFP]), .sw_i(tim[A_VSW]), .bp_i(tim[A_VBP]),
    .cnt_o(y_o), .last_o(v_last), .active_o(v_act), .sync_o(v_sync),
    .sync_start_o(v_start)
  );

  rtg_drive u_drive (
    .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_i(ctrl),
    .h_raw_i(h_sync), .v_raw_i(v_sync), .de_raw_i(h_act && v_act),
    .set_i(vs_set), .clr_i(st_clr), .mask_i(irq_mask),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
    .pix_inv_o(pix_inv_o), .clk_inv_o(clk_inv_o), .stat_o(irq_stat), .irq_o(irq_o)
  );

  logic unused_start;
  assign unused_start = h_start;
endmodule

// File: rtl/rtg_checker.sv
module rtg_checker import rtg_pkg::*; #(
  parameter int unsigned PW = 14
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          restart_i,
  input logic          set_i,
  input logic          clr_i,
  input logic          stat_i,
  input logic          mask_i,
  input logic          irq_i,
  input logic [PW-1:0] x_i,
  input logic [PW-1:0] y_i,
  input ctrl_t         ctrl_i,
  input logic          hsync_i
);
  a_r1_x_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !restart_i |=> (x_i == '0 || x_i == $past(x_i) + PW'(1)));

  a_r6_restart_home: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (x_i == '0 && y_i == '0));

  a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> stat_i);

  a_r8_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !stat_i);

  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !set_i) |=> $stable(stat_i));

  a_r9_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_i |-> !irq_i);

  a_r9_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_i && !mask_i) |-> irq_i);

  a_r4_h_parked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i.h_en |-> (hsync_i == ctrl_i.h_inv));
endmodule

bind raster_timing_gen rtg_checker #(.PW(PW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(restart), .set_i(vs_set),
  .clr_i(st_clr), .stat_i(irq_stat), .mask_i(irq_mask), .irq_i(irq_o),
  .x_i(x_o), .y_i(y_o), .ctrl_i(ctrl), .hsync_i(hsync_o)
);

// File: tb/raster_timing_gen_bench.sv
`timescale 1ns/1ps
module raster_timing_gen_bench;
  localparam int unsigned CNT_W = 12;
  localparam int unsigned PW    = CNT_W + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [CNT_W-1:0] wr_data = '0;
  logic hsync, vsync, de, pix_inv, clk_inv, irq;
  logic [PW-1:0] x, y;
  int checks = 0;
  int errs = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  raster_timing_gen #(.CNT_W(CNT_W)) u_raster_timing_gen (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .hsync_o(hsync), .vsync_o(vsync), .de_o(de),
    .pix_inv_o(pix_inv), .clk_inv_o(clk_inv), .x_o(x), .y_o(y), .irq_o(irq)
  );

  // geometry: line 4+2+3+1 = 10 px, frame 3+1+2+1 = 7 lines
  localparam int NV = 14;
  localparam int TK[NV] = '{0, 3, 4, 6, 8, 9, 12, 29, 30, 40, 56, 60, 69, 70};
  localparam int TX[NV] = '{0, 3, 4, 6, 8, 9,  2,  9,  0,  0,  6,  0,  9,  0};
  localparam int TY[NV] = '{0, 0, 0, 0, 0, 0,  1,  2,  3,  4,  5,  6,  6,  0};
  localparam logic [2:0] TE[NV] = '{3'b001, 3'b001, 3'b000, 3'b100, 3'b100, 3'b000,
    3'b001, 3'b000, 3'b000, 3'b010, 3'b110, 3'b000, 3'b000, 3'b001};

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1;
    wr_addr = 4'(a);
    wr_data = CNT_W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk_hvd(input string tag, input logic [2:0] e);
    chk({tag, " hsync"}, int'(hsync), int'(e[2]));
    chk({tag, " vsync"}, int'(vsync), int'(e[1]));
    chk({tag, " de"},    int'(de),    int'(e[0]));
  endtask

  // apply control word, restart, sample at x0/y0, x6/y0, x0/y4
  task automatic probe(input int cv, input string tag,
                       input logic [2:0] e0, input logic [2:0] e6, input logic [2:0] e40);
    wr(8, cv);
    wr(9, 0);
    chk_hvd({tag, " k0"}, e0);
    repeat (6) @(negedge clk);
    chk_hvd({tag, " k6"}, e6);
    repeat (34) @(negedge clk);
    chk_hvd({tag, " k40"}, e40);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
    end
  end

  initial begin
    int cur;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    chk("R10 hsync", int'(hsync), 0);
    chk("R10 vsync", int'(vsync), 0);
    chk("R10 de", int'(de), 0);
    chk("R10 irq", int'(irq), 0);
    chk("R10 pix_inv", int'(pix_inv), 0);
    chk("R10 clk_inv", int'(clk_inv), 0);
    chk("R10 x", int'(x), 0);
    chk("R10 y", int'(y), 0);

    wr(0, 1); wr(1, 2); wr(2, 0); wr(3, 3);
    wr(4, 0); wr(5, 1); wr(6, 0); wr(7, 2);
    wr(8, 'h15);
    wr(9, 'hBEE);

    // R1 R2 R3 table walk
    cur = 0;
    for (int i = 0; i < NV; i++) begin
      repeat (TK[i] - cur) @(negedge clk);
      cur = TK[i];
      chk($sformatf("R1 x k%0d", TK[i]), int'(x), TX[i]);
      chk($sformatf("R2 y k%0d", TK[i]), int'(y), TY[i]);
      chk_hvd($sformatf("R3 k%0d", TK[i]), TE[i]);
    end

    // R7 staged geometry
    wr(9, 0);
    wr(3, 5);
    repeat (3) @(negedge clk);
    chk("R7 x old frame", int'(x), 4);
    chk("R7 de old width", int'(de), 0);
    repeat (66) @(negedge clk);
    chk("R7 x wrap", int'(x), 0);
    chk("R7 y wrap", int'(y), 0);
    repeat (4) @(negedge clk);
    chk("R7 de new width", int'(de), 1);
    repeat (8) @(negedge clk);
    chk("R7 x new total", int'(x), 0);
    chk("R7 y new total", int'(y), 1);
    wr(3, 3);
    wr(9, 0);

    // R6 mid-frame restart
    repeat (25) @(negedge clk);
    chk("R6 x before", int'(x), 5);
    wr(9, 'h5A5);
    chk("R6 x", int'(x), 0);
    chk("R6 y", int'(y), 0);
    chk("R6 de", int'(de), 1);

    // R4 R5 enable / polarity
    probe('h17, "R5 h_inv", 3'b101, 3'b000, 3'b110);
    probe('h16, "R4 h_off", 3'b101, 3'b100, 3'b110);
    probe('h3D, "R5 v_de_inv", 3'b010, 3'b111, 3'b001);
    probe('h00, "R4 all_off", 3'b000, 3'b000, 3'b000);
    probe('h2A, "R4 off_inv", 3'b111, 3'b111, 3'b111);
    wr(8, 'h40);
    chk("R5 pix_inv", int'(pix_inv), 1);
    chk("R5 clk_inv", int'(clk_inv), 0);
    wr(8, 'h80);
    chk("R5 pix_inv2", int'(pix_inv), 0);
    chk("R5 clk_inv2", int'(clk_inv), 1);

    // R8 R9 interrupt
    wr(8, 'h15);
    wr(9, 0);
    wr(10, 1);
    wr(11, 0);
    chk("R8 cleared", int'(irq), 0);
    repeat (38) @(negedge clk);
    chk("R8 before set", int'(irq), 0);
    @(negedge clk);
    chk("R8 set", int'(irq), 1);
    wr(10, 1);
    chk("R8 w1c", int'(irq), 0);
    wr(11, 1);
    repeat (68) @(negedge clk);
    chk("R9 masked", int'(irq), 0);
    wr(11, 0);
    chk("R9 status kept", int'(irq), 1);
    wr(10, 1);
    repeat (67) @(negedge clk);
    chk("R8 idle", int'(irq), 0);
    wr(10, 1);
    chk("R8 set wins", int'(irq), 1);
    wr(10, 0);
    chk("R8 write zero", int'(irq), 1);

    // R10 asynchronous reset mid-run
    #1 rst_n = 1'b0;
    #1;
    chk("R10 async irq", int'(irq), 0);
    chk("R10 async hsync", int'(hsync), 0);
    chk("R10 async de", int'(de), 0);
    chk("R10 async x", int'(x), 0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule